// File: doc/BRIEF.md
# Dual-Standard Video Sync Generator

This block produces the horizontal and vertical timing for a monochrome CCD camera from one master clock. The master clock is halved to a pixel rate. A pixel counter spans one line and a line counter spans one interlaced frame. Two static select pins pick the television standard and the sensor width, and these set the line length and the frame length. Every output is decoded from the counter state and then registered. The outputs are the horizontal and vertical drive strobes, composite sync, composite blanking, two clamp strobes, a one-pixel field-start pulse for neighbouring blocks, and a field identifier.

The frame is interlaced. With N lines per frame (N odd), the frame holds 2N half-lines and each field holds N of them. The first field starts at line 0, pixel 0. The second field starts halfway along line (N-1)/2. Every horizontal window is set for the wide sensor. The narrow sensor uses each window scaled by two thirds, rounded down, so the windows keep the same fraction of a line. The select pins are meant to change only while reset is held.

Top module: `vsync_timing_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counters clear and the outputs go idle after that edge: `hd_n`, `vd_n`, `csync_n` and `cblank_n` high; `clamp1`, `clamp2`, `field_pulse` and `field_odd` low.
- R2: The pixel position advances on every second master clock, starting with the second edge after reset is released. A line lasts `PIX_EIA_WIDE` (910) pixels when `std_ccir`=0 and `wide_760`=1. It lasts `PIX_CCIR_WIDE` (908) pixels when `std_ccir`=1 and `wide_760`=1. It lasts `PIX_NARROW` (606) pixels whenever `wide_760`=0.
- R3: A frame lasts `LINES_EIA` (525) lines when `std_ccir`=0 and `LINES_CCIR` (625) lines when `std_ccir`=1. The half-line index is 2*line+(pixel >= length/2). `field_odd` is high while that index is at least N, which is the second field.
- R4: `hd_n` is low while pixel < HSYNC_W (66 wide). For a narrow sensor, each horizontal width and start in R4 and R6 to R9 is floor(wide value * 2 / 3).
- R5: `vd_n` is low for the first 2*`VD_LINES` (6) half-lines of each field.
- R6: For the first 2*`VSER_LINES` (18) half-lines of a field, `csync_n` is low in each half-line except its last SER_W (33 wide) pixels, where it is high. For the rest of the field, `csync_n` equals `hd_n`.
- R7: `cblank_n` is low when pixel < HBLANK_W (150 wide), when pixel >= length - HFP_W (20 wide), or during the first 2*`VBLANK_LINES` (20 lines) half-lines of a field.
- R8: `clamp1` is high for pixels in [CLP1_START, CLP1_START+CLP1_W) (74, 30 wide), except during vertical blanking.
- R9: `clamp2` is high for pixels in [CLP2_START, CLP2_START+CLP2_W) (160, 24 wide), except during vertical blanking. It never overlaps `clamp1`.
- R10: `field_pulse` is high for one pixel period (two master clocks) at the first pixel of each field, which gives exactly two pulses per frame.
- R11: Each output shows the counter state that was held one master clock earlier, so the first state after reset appears one edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (twice the pixel rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| std_ccir | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| wide_760 | input | 1 | Sensor select: 0 = 510H narrow, 1 = 760H wide |
| hd_n | output | 1 | Horizontal drive, active low |
| vd_n | output | 1 | Vertical drive, active low |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blanking, active low |
| clamp1 | output | 1 | Back-porch clamp strobe, active high |
| clamp2 | output | 1 | Optical-black clamp strobe, active high |
| field_pulse | output | 1 | Field start strobe, one pixel long |
| field_odd | output | 1 | High during the second field |

## Verification
The bench goes after the second field's start halfway along a line. A design that started it on a whole line would shift `vd_n`, the serrations and `field_pulse` by half a line, and would show a wrong count of `field_odd` cycles over one frame. It checks every line at its last pixel and every frame at its last line, in all four standard and sensor combinations. An off-by-one terminal count would stretch the line or the frame and put every later edge out of place. It also checks the narrow-sensor scaling of all windows, the serration edge at the end of each half-line, and reset applied in the middle of a run. A design that lost the divide-by-two phase or the one-clock output latency would fail the comparison on the very first pixel.

// File: rtl/vsg_pkg.sv
// Package vsg_pkg
// Shared output bundle, the idle value of that bundle, and the helpers
// used to size counters and scale horizontal windows for narrow sensors.
package vsg_pkg;

    // Registered output bundle of the sync generator.
    typedef struct packed {
        logic hd_n;
        logic vd_n;
        logic csync_n;
        logic cblank_n;
        logic clamp1;
        logic clamp2;
        logic field_pulse;
        logic field_odd;
    } vsg_out_t;

    // Value driven while reset is held: all strobes inactive.
    localparam vsg_out_t VSG_IDLE = '{
        hd_n: 1'b1, vd_n: 1'b1, csync_n: 1'b1, cblank_n: 1'b1,
        clamp1: 1'b0, clamp2: 1'b0, field_pulse: 1'b0, field_odd: 1'b0
    };

    // Scale a wide-sensor pixel count to the narrow sensor (x2/3, floor).
    function automatic int narrow_width(input int wide_value);
        return (wide_value * 2) / 3;
    endfunction

    // Largest of three counts, used to size the pixel counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vsg_prescale.sv
// Module vsg_prescale
// Halves the master clock into a pixel-advance enable. The enable is high
// on every second master clock, starting with the first clock after reset.
// Assumes a synchronous active-low reset.
module vsg_prescale (
    input  logic clk,
    input  logic rst_n,
    output logic adv
);

    logic phase;

    // Toggle the phase bit each master clock; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    assign adv = phase;

endmodule

// File: rtl/vsg_counters.sv
// Module vsg_counters
// Pixel and line counters of one interlaced frame. The pixel counter
// wraps at h_len-1 and the line counter at n_lines-1. Both move only
// when adv is high. The limits are taken from static select pins, so a
// greater-or-equal compare keeps the counters in range even if a select
// changes outside reset.
module vsg_counters #(
    parameter int PX_W = 10,
    parameter int LN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [PX_W-1:0] h_len,
    input  logic [LN_W-1:0] n_lines,
    output logic [PX_W-1:0] px,
    output logic [LN_W-1:0] ln
);

    logic px_last;
    logic ln_last;

    // Terminal-count detection for the line and frame wraps.
    always_comb begin
        px_last = (px >= h_len - PX_W'(1));
        ln_last = (ln >= n_lines - LN_W'(1));
    end

    // Advance the pixel position and carry into the line count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px <= '0;
            ln <= '0;
        end else if (adv) begin
            if (px_last) begin
                px <= '0;
                ln <= ln_last ? '0 : ln + LN_W'(1);
            end else begin
                px <= px + PX_W'(1);
            end
        end
    end

endmodule

// File: rtl/vsg_decode.sv
// Module vsg_decode
// Decodes the counter state into the sync, blanking, clamp and field
// outputs and registers them. The position is folded into a half-line
// index so that both fields share one vertical decode: the second field
// starts at half-line n_lines, halfway along a line. Horizontal windows
// are given for the wide sensor and scaled by 2/3 for the narrow one.
// Assumes h_len is even and n_lines is odd.
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int PX_W         = 10,
    parameter int LN_W         = 10,
    parameter int HSYNC_W      = 66,
    parameter int HBLANK_W     = 150,
    parameter int HFP_W        = 20,
    parameter int CLP1_START   = 74,
    parameter int CLP1_W       = 30,
    parameter int CLP2_START   = 160,
    parameter int CLP2_W       = 24,
    parameter int SER_W        = 33,
    parameter int VD_LINES     = 3,
    parameter int VSER_LINES   = 9,
    parameter int VBLANK_LINES = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_760,
    input  logic [PX_W-1:0] px,
    input  logic [PX_W-1:0] h_len,
    input  logic [LN_W-1:0] ln,
    input  logic [LN_W-1:0] n_lines,
    output vsg_out_t        q
);

    localparam int HL_W = LN_W + 1;

    // Narrow-sensor windows, derived from the wide ones.
    localparam int N_HSYNC_W    = narrow_width(HSYNC_W);
    localparam int N_HBLANK_W   = narrow_width(HBLANK_W);
    localparam int N_HFP_W      = narrow_width(HFP_W);
    localparam int N_CLP1_START = narrow_width(CLP1_START);
    localparam int N_CLP1_W     = narrow_width(CLP1_W);
    localparam int N_CLP2_START = narrow_width(CLP2_START);
    localparam int N_CLP2_W     = narrow_width(CLP2_W);
    localparam int N_SER_W      = narrow_width(SER_W);

    // Vertical windows counted in half-lines from the field start.
    localparam logic [HL_W-1:0] VD_HL   = HL_W'(2 * VD_LINES);
    localparam logic [HL_W-1:0] VSER_HL = HL_W'(2 * VSER_LINES);
    localparam logic [HL_W-1:0] VB_HL   = HL_W'(2 * VBLANK_LINES);

    logic [PX_W-1:0] w_hs, w_hb, w_fp, w_c1s, w_c1w, w_c2s, w_c2w, w_ser;
    logic [PX_W-1:0] half, hp;
    logic            second_half;
    logic [HL_W-1:0] hl, n_hl, fh;
    logic            odd_field;
    logic            in_vd, in_vser, in_vblank;
    logic            hsync, hblank, ser_low, clp1_win, clp2_win;
    vsg_out_t        d;

    // Pick the horizontal window set for the selected sensor width.
    always_comb begin
        if (wide_760) begin
            w_hs  = PX_W'(HSYNC_W);
            w_hb  = PX_W'(HBLANK_W);
            w_fp  = PX_W'(HFP_W);
            w_c1s = PX_W'(CLP1_START);
            w_c1w = PX_W'(CLP1_W);
            w_c2s = PX_W'(CLP2_START);
            w_c2w = PX_W'(CLP2_W);
            w_ser = PX_W'(SER_W);
        end else begin
            w_hs  = PX_W'(N_HSYNC_W);
            w_hb  = PX_W'(N_HBLANK_W);
            w_fp  = PX_W'(N_HFP_W);
            w_c1s = PX_W'(N_CLP1_START);
            w_c1w = PX_W'(N_CLP1_W);
            w_c2s = PX_W'(N_CLP2_START);
            w_c2w = PX_W'(N_CLP2_W);
            w_ser = PX_W'(N_SER_W);
        end
    end

    // Fold the position into a half-line index and a position in the field.
    always_comb begin
        half        = h_len >> 1;
        second_half = (px >= half);
        hp          = second_half ? (px - half) : px;
        hl          = {ln, second_half};
        n_hl        = {1'b0, n_lines};
        odd_field   = (hl >= n_hl);
        fh          = odd_field ? (hl - n_hl) : hl;
    end

    // Vertical and horizontal windows.
    always_comb begin
        in_vd     = (fh < VD_HL);
        in_vser   = (fh < VSER_HL);
        in_vblank = (fh < VB_HL);
        hsync     = (px < w_hs);
        hblank    = (px < w_hb) || (px >= h_len - w_fp);
        ser_low   = (hp < half - w_ser);
        clp1_win  = (px >= w_c1s) &&
                    ({1'b0, px} < {1'b0, w_c1s} + {1'b0, w_c1w});
        clp2_win  = (px >= w_c2s) &&
                    ({1'b0, px} < {1'b0, w_c2s} + {1'b0, w_c2w});
    end

    // Combine the windows into the next output value.
    always_comb begin
        d.hd_n        = ~hsync;
        d.vd_n        = ~in_vd;
        d.csync_n     = in_vser ? ~ser_low : ~hsync;
        d.cblank_n    = ~(hblank || in_vblank);
        d.clamp1      = clp1_win && !in_vblank;
        d.clamp2      = clp2_win && !in_vblank;
        d.field_pulse = (fh == '0) && (hp == '0);
        d.field_odd   = odd_field;
    end

    // Register the outputs; idle during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= VSG_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/vsync_timing_gen.sv
// Module vsync_timing_gen
// Dual-standard sync generator for a monochrome CCD camera. The master
// clock is halved into a pixel enable. Pixel and line counters sized for
// the selected standard and sensor then drive a registered decoder. The
// select pins are static and should change only while reset is held.
module vsync_timing_gen #(
    parameter int PIX_EIA_WIDE  = 910,
    parameter int PIX_CCIR_WIDE = 908,
    parameter int PIX_NARROW    = 606,
    parameter int LINES_EIA     = 525,
    parameter int LINES_CCIR    = 625,
    parameter int HSYNC_W       = 66,
    parameter int HBLANK_W      = 150,
    parameter int HFP_W         = 20,
    parameter int CLP1_START    = 74,
    parameter int CLP1_W        = 30,
    parameter int CLP2_START    = 160,
    parameter int CLP2_W        = 24,
    parameter int SER_W         = 33,
    parameter int VD_LINES      = 3,
    parameter int VSER_LINES    = 9,
    parameter int VBLANK_LINES  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_ccir,
    input  logic wide_760,
    output logic hd_n,
    output logic vd_n,
    output logic csync_n,
    output logic cblank_n,
    output logic clamp1,
    output logic clamp2,
    output logic field_pulse,
    output logic field_odd
);

    localparam int PX_W = $clog2(vsg_pkg::max3(PIX_EIA_WIDE, PIX_CCIR_WIDE, PIX_NARROW));
    localparam int LN_W = $clog2((LINES_EIA > LINES_CCIR) ? LINES_EIA : LINES_CCIR);

    logic              adv;
    logic [PX_W-1:0]   h_len;
    logic [LN_W-1:0]   n_lines;
    logic [PX_W-1:0]   px;
    logic [LN_W-1:0]   ln;
    vsg_pkg::vsg_out_t q;

    // Line and frame lengths for the selected standard and sensor.
    always_comb begin
        if (!wide_760) begin
            h_len = PX_W'(PIX_NARROW);
        end else if (std_ccir) begin
            h_len = PX_W'(PIX_CCIR_WIDE);
        end else begin
            h_len = PX_W'(PIX_EIA_WIDE);
        end
        n_lines = std_ccir ? LN_W'(LINES_CCIR) : LN_W'(LINES_EIA);
    end

    vsg_prescale u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv)
    );

    vsg_counters #(
        .PX_W (PX_W),
        .LN_W (LN_W)
    ) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .h_len   (h_len),
        .n_lines (n_lines),
        .px      (px),
        .ln      (ln)
    );

    vsg_decode #(
        .PX_W         (PX_W),
        .LN_W         (LN_W),
        .HSYNC_W      (HSYNC_W),
        .HBLANK_W     (HBLANK_W),
        .HFP_W        (HFP_W),
        .CLP1_START   (CLP1_START),
        .CLP1_W       (CLP1_W),
        .CLP2_START   (CLP2_START),
        .CLP2_W       (CLP2_W),
        .SER_W        (SER_W),
        .VD_LINES     (VD_LINES),
        .VSER_LINES   (VSER_LINES),
        .VBLANK_LINES (VBLANK_LINES)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_760 (wide_760),
        .px       (px),
        .h_len    (h_len),
        .ln       (ln),
        .n_lines  (n_lines),
        .q        (q)
    );

    // Unpack the registered bundle onto the ports.
    assign hd_n        = q.hd_n;
    assign vd_n        = q.vd_n;
    assign csync_n     = q.csync_n;
    assign cblank_n    = q.cblank_n;
    assign clamp1      = q.clamp1;
    assign clamp2      = q.clamp2;
    assign field_pulse = q.field_pulse;
    assign field_odd   = q.field_odd;

endmodule

// File: rtl/vsg_checker.sv
// Module vsg_checker
// Temporal checks on the sync generator, attached by the bind at the end
// of this file. It looks at the pixel enable, the counters and the ports.
module vsg_checker #(
    parameter int PX_W = 10,
    parameter int LN_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adv,
    input logic [PX_W-1:0] px,
    input logic [PX_W-1:0] h_len,
    input logic [LN_W-1:0] ln,
    input logic [LN_W-1:0] n_lines,
    input logic            hd_n,
    input logic            vd_n,
    input logic            cblank_n,
    input logic            clamp1,
    input logic            clamp2,
    input logic            field_pulse
);

    logic seen = 1'b0;

    // Mark that one clock edge has passed, so $past has a real history.
    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    // R1: one edge after reset is sampled low, every strobe is idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        seen && !$past(rst_n) |-> hd_n && vd_n && cblank_n && !clamp1 && !clamp2 && !field_pulse);

    // R2: the pixel enable alternates on every master clock out of reset.
    p_adv_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) |-> adv != $past(adv));

    // R2: the pixel position holds on the clocks without the enable.
    p_px_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rst_n) && !$past(adv) |-> px == $past(px));

    // R2: the pixel position stays below the line length.
    p_px_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        px < h_len);

    // R3: the line count stays below the frame length.
    p_ln_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ln < n_lines);

    // R7: vertical drive lies inside composite blanking.
    p_vd_in_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vd_n |-> !cblank_n);

    // R8: clamps are suppressed while vertical drive is active.
    p_clamp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vd_n |-> !clamp1 && !clamp2);

    // R9: the two clamp strobes never overlap.
    p_clamp_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp1 && clamp2));

    // R10: a field start strobe always falls inside vertical drive.
    p_field_in_vd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        field_pulse |-> !vd_n);

endmodule

bind vsync_timing_gen vsg_checker #(
    .PX_W (PX_W),
    .LN_W (LN_W)
) u_vsg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (adv),
    .px          (px),
    .h_len       (h_len),
    .ln          (ln),
    .n_lines     (n_lines),
    .hd_n        (hd_n),
    .vd_n        (vd_n),
    .cblank_n    (cblank_n),
    .clamp1      (clamp1),
    .clamp2      (clamp2),
    .field_pulse (field_pulse)
);

// File: tb/vsync_timing_gen_test.sv
// Bench for vsync_timing_gen. It uses reduced line and frame sizes so
// that whole frames fit in the run. A reference model of the counters
// steps with every clock, and bench functions derive the expected
// outputs from the requirements.
module vsync_timing_gen_test;

    localparam int CLK_PERIOD = 10;

    localparam int T_PIX_EIA  = 182;
    localparam int T_PIX_CCIR = 180;
    localparam int T_PIX_NAR  = 122;
    localparam int T_LN_EIA   = 45;
    localparam int T_LN_CCIR  = 55;
    localparam int T_HS       = 12;
    localparam int T_HB       = 27;
    localparam int T_FP       = 4;
    localparam int T_C1S      = 15;
    localparam int T_C1W      = 6;
    localparam int T_C2S      = 30;
    localparam int T_C2W      = 5;
    localparam int T_SER      = 6;
    localparam int T_VD       = 2;
    localparam int T_VSER     = 4;
    localparam int T_VB       = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic std_ccir = 1'b0;
    logic wide_760 = 1'b0;
    logic hd_n, vd_n, csync_n, cblank_n, clamp1, clamp2, field_pulse, field_odd;

    int checks = 0;
    int fails = 0;
    int cur_ph, cur_px, cur_ln;
    bit seg_bad;
    string tag [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsync_timing_gen #(
        .PIX_EIA_WIDE (T_PIX_EIA), .PIX_CCIR_WIDE (T_PIX_CCIR), .PIX_NARROW (T_PIX_NAR),
        .LINES_EIA (T_LN_EIA), .LINES_CCIR (T_LN_CCIR),
        .HSYNC_W (T_HS), .HBLANK_W (T_HB), .HFP_W (T_FP),
        .CLP1_START (T_C1S), .CLP1_W (T_C1W), .CLP2_START (T_C2S), .CLP2_W (T_C2W),
        .SER_W (T_SER), .VD_LINES (T_VD), .VSER_LINES (T_VSER), .VBLANK_LINES (T_VB)
    ) uut (
        .clk (clk), .rst_n (rst_n), .std_ccir (std_ccir), .wide_760 (wide_760),
        .hd_n (hd_n), .vd_n (vd_n), .csync_n (csync_n), .cblank_n (cblank_n),
        .clamp1 (clamp1), .clamp2 (clamp2), .field_pulse (field_pulse), .field_odd (field_odd)
    );

    // Line length in pixels, per R2.
    function automatic int line_len(bit ccir, bit wide);
        if (!wide) return T_PIX_NAR;
        return ccir ? T_PIX_CCIR : T_PIX_EIA;
    endfunction

    // Frame length in lines, per R3.
    function automatic int frame_len(bit ccir);
        return ccir ? T_LN_CCIR : T_LN_EIA;
    endfunction

    // Horizontal window for the sensor width, per R4 (narrow = floor(2/3)).
    function automatic int hw(int v, bit wide);
        return wide ? v : (v * 2) / 3;
    endfunction

    // Expected output vector {hd,vd,cs,cb,c1,c2,fp,fo} for a pixel position.
    function automatic logic [7:0] expect_out(int px, int ln, bit ccir, bit wide);
        int h, n, half, hl, fh, hp;
        bit hs, vdw, vser, vb, c1, c2, hbl, cs_n;
        h    = line_len(ccir, wide);
        n    = frame_len(ccir);
        half = h / 2;
        hl   = 2 * ln + ((px >= half) ? 1 : 0);
        fh   = (hl >= n) ? hl - n : hl;
        hp   = (px >= half) ? px - half : px;
        hs   = px < hw(T_HS, wide);
        vdw  = fh < 2 * T_VD;
        vser = fh < 2 * T_VSER;
        vb   = fh < 2 * T_VB;
        hbl  = (px < hw(T_HB, wide)) || (px >= h - hw(T_FP, wide));
        c1   = !vb && px >= hw(T_C1S, wide) && px < hw(T_C1S, wide) + hw(T_C1W, wide);
        c2   = !vb && px >= hw(T_C2S, wide) && px < hw(T_C2S, wide) + hw(T_C2W, wide);
        cs_n = vser ? !(hp < half - hw(T_SER, wide)) : !hs;
        return {!hs, !vdw, cs_n, !(hbl || vb), c1, c2, (fh == 0 && hp == 0), (hl >= n)};
    endfunction

    function automatic logic [7:0] dut_out();
        return {hd_n, vd_n, csync_n, cblank_n, clamp1, clamp2, field_pulse, field_odd};
    endfunction

    // Count one check; report a failure with requirement and values.
    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Hold reset with the given selects, check idle outputs (R1), release.
    task automatic do_reset(bit ccir, bit wide, int cyc);
        @(negedge clk);
        rst_n    = 1'b0;
        std_ccir = ccir;
        wide_760 = wide;
        repeat (cyc) @(negedge clk);
        check(dut_out() == 8'hF0, "R1 idle outputs under reset", dut_out(), 8'hF0);
        rst_n   = 1'b1;
        cur_ph  = 0;
        cur_px  = 0;
        cur_ln  = 0;
        seg_bad = 1'b0;
    endtask

    // Step the model by one master clock, then compare against the state one
    // clock old (R11). The pixel moves on odd phases only (R2).
    task automatic step_and_compare();
        int pv_px, pv_ln;
        logic [7:0] exp, act;
        @(negedge clk);
        pv_px = cur_px;
        pv_ln = cur_ln;
        if (cur_ph == 1) begin
            if (cur_px == line_len(std_ccir, wide_760) - 1) begin
                cur_px = 0;
                cur_ln = (cur_ln == frame_len(std_ccir) - 1) ? 0 : cur_ln + 1;
            end else begin
                cur_px = cur_px + 1;
            end
        end
        cur_ph = 1 - cur_ph;
        if (seg_bad) return;
        exp = expect_out(pv_px, pv_ln, std_ccir, wide_760);
        act = dut_out();
        if (act != exp) begin
            for (int i = 7; i >= 0; i--) begin
                if (act[i] != exp[i]) begin
                    check(1'b0, {tag[7 - i], " (R2 R11 timing)"}, act, exp);
                    break;
                end
            end
            seg_bad = 1'b1;
        end else begin
            check(1'b1, "model", act, exp);
        end
    endtask

    // One whole frame from reset: count field pulses (R10), odd-field clocks
    // (R3) and horizontal drive falls (R2, R4) alongside the model compare.
    task automatic frame_test(bit ccir, bit wide);
        int h, n, pulses, odd_clk, lines;
        logic fp_q, hd_q;
        h = line_len(ccir, wide);
        n = frame_len(ccir);
        do_reset(ccir, wide, 3);
        pulses = 0; odd_clk = 0; lines = 0;
        fp_q = 1'b0; hd_q = 1'b1;
        for (int c = 0; c < 2 * h * n; c++) begin
            step_and_compare();
            if (field_pulse && !fp_q) pulses++;
            if (!hd_n && hd_q) lines++;
            if (field_odd) odd_clk++;
            fp_q = field_pulse;
            hd_q = hd_n;
        end
        check(pulses == 2, "R10 field pulses per frame", pulses, 2);
        check(odd_clk == h * n, "R3 second-field clocks per frame", odd_clk, h * n);
        check(lines == n, "R2 R4 lines per frame", lines, n);
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tag[0] = "R4 hd_n";
        tag[1] = "R5 vd_n";
        tag[2] = "R6 csync_n";
        tag[3] = "R7 cblank_n";
        tag[4] = "R8 clamp1";
        tag[5] = "R9 clamp2";
        tag[6] = "R10 field_pulse";
        tag[7] = "R3 field_odd";
        void'($urandom(32'd20240611));

        // Directed: a full frame in each standard and sensor combination.
        frame_test(1'b0, 1'b1);
        frame_test(1'b1, 1'b1);
        frame_test(1'b0, 1'b0);
        frame_test(1'b1, 1'b0);

        // Random: reset mid-run with random selects and run lengths.
        for (int s = 0; s < 8; s++) begin
            bit rc, rw;
            int len;
            rc  = 1'($urandom % 2);
            rw  = 1'($urandom % 2);
            len = 2000 + int'($urandom % 6000);
            do_reset(rc, rw, 2 + int'($urandom % 4));
            repeat (len) step_and_compare();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule